// File: doc/BRIEF.md
# Multiframe Clock Generator with SYSREF Alignment

This block keeps the local multiframe timing of a subclass 1 serial converter link. It runs on the character clock. Each clock carries `OCT_PER_CLK` octets per lane, so each clock advances an octet position counter by that amount. The counter wraps at the multiframe length, which is K frames of F octets each. F and K are chosen at run time from a small set of encodings. From the counter the block derives three outputs: a strobe for the cycle that contains a multiframe boundary, the lane inside the clock word where that boundary falls, and a per-lane mask marking the octets that start a frame.

A rising edge on the SYSREF input restarts the counter, so the multiframe boundary sits on that edge. This gives the same boundary phase after every power cycle. SYSREF normally repeats every two multiframes. A correct system therefore sees every edge after the first land on a boundary the counter already holds. An edge that lands anywhere else sets a sticky misalignment flag. Until the first SYSREF edge is taken, the counter free-runs from reset and the aligned status stays low. An optional mode accepts only the first edge and ignores all later ones.

Top module: `lmfc_align_gen`

## Requirements
- R1: While `rst_i` is high and after its release, `octet_pos_o` is 0 and `aligned_o` and `misalign_o` are 0.
- R2: The multiframe length P is F×K octets. F is 1, 2, 4, 4 for `frame_sel_i` values 0, 1, 2, 3. K is 16 when `mf_sel_i` is 0 and 32 when it is 1. Apart from a realignment, `octet_pos_o` (the position of lane 0) becomes (pos + OCT_PER_CLK) mod P at each clock edge.
- R3: `lmfc_strobe_o` is 1 in a cycle exactly when one lane of that clock word holds octet 0. That lane is given by `lmfc_lane_o`: 0 when `octet_pos_o` is 0, otherwise P − `octet_pos_o`. `lmfc_lane_o` is 0 when there is no strobe.
- R4: Bit L of `frame_start_o` is 1 exactly when (`octet_pos_o` + L) mod F is 0.
- R5: A SYSREF rising edge sampled high at clock edge n (low at edge n−1) is detected in the cycle that follows. The detection cycle counts as octet 0, so after edge n+1 `octet_pos_o` equals OCT_PER_CLK. A SYSREF held high does not retrigger.
- R6: `aligned_o` rises at the edge where the first accepted SYSREF edge takes effect and stays high until reset. Before that edge the counter free-runs from 0.
- R7: `misalign_o` is set and held until reset when an edge is accepted while `aligned_o` is 1 and the detection cycle's position is not 0. An edge detected at position 0 leaves the flag unchanged.
- R8: With `one_shot_i` high, SYSREF edges detected while `aligned_o` is 1 are ignored: the position keeps advancing and `misalign_o` does not change.
- R9: A SYSREF repeating every two multiframes and first taken at position 0 keeps `misalign_o` at 0 and leaves the position sequence identical to free-running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Character clock |
| rst_i | input | 1 | Synchronous reset, active high |
| sysref_i | input | 1 | SYSREF level, sampled on the character clock |
| frame_sel_i | input | 2 | Frame length select (F), held static outside reset |
| mf_sel_i | input | 1 | Frames per multiframe select (K), held static outside reset |
| one_shot_i | input | 1 | Accept only the first SYSREF edge |
| octet_pos_o | output | 7 | Multiframe octet position of lane 0 |
| lmfc_strobe_o | output | 1 | The clock word contains a multiframe boundary |
| lmfc_lane_o | output | LANE_W (2) | Lane holding the boundary octet |
| frame_start_o | output | OCT_PER_CLK (4) | Per-lane frame start mask |
| aligned_o | output | 1 | A SYSREF edge has been taken since reset |
| misalign_o | output | 1 | Sticky: an edge arrived off a boundary |

## Verification
A SYSREF level driven before clock edge n is detected in the next cycle. Its effect on the position, `aligned_o` and `misalign_o` can be seen only after edge n+1, two edges after the drive. The strobe, lane and frame mask are decoded from the position in the same cycle. The bench drives inputs on the falling edge and compares every output on each later falling edge against a reference model. The model advances on the rising edge with the two-edge SYSREF delay built in. Directed sequences count edges from the reset release so that each fixed expected value is sampled in the cycle it is due. A second instance with three octets per clock checks boundaries that fall inside the clock word.

// File: rtl/lmfc_pkg.sv
package lmfc_pkg;

    localparam int unsigned FRAME_OCT_MAX = 4;
    localparam int unsigned MF_FRAMES_LO  = 16;
    localparam int unsigned MF_FRAMES_HI  = 32;
    localparam int unsigned MF_OCT_MAX    = FRAME_OCT_MAX * MF_FRAMES_HI;
    localparam int unsigned POS_W         = $clog2(MF_OCT_MAX);
    localparam int unsigned PER_W         = POS_W + 1;

    typedef struct packed {
        logic smp;
        logic prv;
    } edge_state_t;

    typedef struct packed {
        logic [POS_W-1:0] pos;
        logic             aligned;
        logic             misalign;
    } ctr_state_t;

    function automatic logic [PER_W-1:0] frame_octets(input logic [1:0] f_sel);
        case (f_sel)
            2'd0:    return PER_W'(1);
            2'd1:    return PER_W'(2);
            default: return PER_W'(FRAME_OCT_MAX);
        endcase
    endfunction

    function automatic logic [PER_W-1:0] mf_octets(input logic [1:0] f_sel, input logic k_sel);
        logic [PER_W-1:0] frames;
        frames = k_sel ? PER_W'(MF_FRAMES_HI) : PER_W'(MF_FRAMES_LO);
        return PER_W'(frames * frame_octets(f_sel));
    endfunction

    function automatic logic [POS_W-1:0] frame_low_mask(input logic [1:0] f_sel);
        logic [PER_W-1:0] f;
        f = frame_octets(f_sel) - PER_W'(1);
        return f[POS_W-1:0];
    endfunction

endpackage

// File: rtl/lmfc_sysref_edge.sv
module lmfc_sysref_edge
    import lmfc_pkg::*;
(
    input  logic clk_i,
    input  logic rst_i,
    input  logic sysref_i,
    output logic rise_o
);

    edge_state_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.smp = sysref_i;
        st_d.prv = st_q.smp;
        rise_o   = st_q.smp & ~st_q.prv;
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/lmfc_octet_counter.sv
module lmfc_octet_counter
    import lmfc_pkg::*;
#(
    parameter int unsigned OCT_PER_CLK = 4
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic             rise_i,
    input  logic             one_shot_i,
    input  logic [PER_W-1:0] period_i,
    output logic [POS_W-1:0] pos_o,
    output logic             aligned_o,
    output logic             misalign_o,
    output logic             accept_o
);

    localparam logic [PER_W-1:0] STEP      = PER_W'(OCT_PER_CLK);
    localparam logic [POS_W-1:0] RESTART_P = POS_W'(OCT_PER_CLK);

    ctr_state_t       st_d, st_q;
    logic [PER_W-1:0] pos_ext;
    logic [PER_W-1:0] sum;

    always_comb begin
        st_d     = st_q;
        pos_ext  = PER_W'(st_q.pos);
        sum      = pos_ext + STEP;
        accept_o = rise_i & ~(one_shot_i & st_q.aligned);
        if (accept_o) begin
            // the detection cycle is octet 0, so the next word starts one step on
            st_d.pos     = RESTART_P;
            st_d.aligned = 1'b1;
            if (st_q.aligned && (st_q.pos != '0)) begin
                st_d.misalign = 1'b1;
            end
        end else if (pos_ext >= period_i) begin
            st_d.pos = '0;
        end else if (sum >= period_i) begin
            st_d.pos = POS_W'(sum - period_i);
        end else begin
            st_d.pos = POS_W'(sum);
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pos_o      = st_q.pos;
    assign aligned_o  = st_q.aligned;
    assign misalign_o = st_q.misalign;

endmodule

// File: rtl/lmfc_lane_decode.sv
module lmfc_lane_decode
    import lmfc_pkg::*;
#(
    parameter int unsigned OCT_PER_CLK = 4,
    parameter int unsigned LANE_W      = 2
) (
    input  logic [POS_W-1:0]       pos_i,
    input  logic [PER_W-1:0]       period_i,
    input  logic [1:0]             frame_sel_i,
    output logic                   strobe_o,
    output logic [LANE_W-1:0]      lane_o,
    output logic [OCT_PER_CLK-1:0] fstart_o
);

    localparam logic [PER_W-1:0] STEP = PER_W'(OCT_PER_CLK);

    logic [PER_W-1:0] pos_ext;
    logic [POS_W-1:0] fmask;

    always_comb begin
        pos_ext = PER_W'(pos_i);
        if (pos_i == '0) begin
            strobe_o = 1'b1;
            lane_o   = '0;
        end else if ((pos_ext < period_i) && ((pos_ext + STEP) > period_i)) begin
            strobe_o = 1'b1;
            lane_o   = LANE_W'(period_i - pos_ext);
        end else begin
            strobe_o = 1'b0;
            lane_o   = '0;
        end
    end

    assign fmask = frame_low_mask(frame_sel_i);

    for (genvar ln = 0; ln < OCT_PER_CLK; ln++) begin : g_lane
        logic [POS_W-1:0] idx;
        assign idx          = pos_i + POS_W'(ln);
        assign fstart_o[ln] = ((idx & fmask) == '0);
    end

endmodule

// File: rtl/lmfc_align_gen.sv
module lmfc_align_gen
    import lmfc_pkg::*;
#(
    parameter int unsigned OCT_PER_CLK = 4,
    localparam int unsigned LANE_W     = (OCT_PER_CLK > 1) ? $clog2(OCT_PER_CLK) : 1
) (
    input  logic                   clk_i,
    input  logic                   rst_i,
    input  logic                   sysref_i,
    input  logic [1:0]             frame_sel_i,
    input  logic                   mf_sel_i,
    input  logic                   one_shot_i,
    output logic [POS_W-1:0]       octet_pos_o,
    output logic                   lmfc_strobe_o,
    output logic [LANE_W-1:0]      lmfc_lane_o,
    output logic [OCT_PER_CLK-1:0] frame_start_o,
    output logic                   aligned_o,
    output logic                   misalign_o
);

    logic             sref_rise;
    logic             sref_take;
    logic [PER_W-1:0] mf_len;

    assign mf_len = mf_octets(frame_sel_i, mf_sel_i);

    lmfc_sysref_edge i_edge (
        .clk_i    (clk_i),
        .rst_i    (rst_i),
        .sysref_i (sysref_i),
        .rise_o   (sref_rise)
    );

    lmfc_octet_counter #(
        .OCT_PER_CLK (OCT_PER_CLK)
    ) i_ctr (
        .clk_i      (clk_i),
        .rst_i      (rst_i),
        .rise_i     (sref_rise),
        .one_shot_i (one_shot_i),
        .period_i   (mf_len),
        .pos_o      (octet_pos_o),
        .aligned_o  (aligned_o),
        .misalign_o (misalign_o),
        .accept_o   (sref_take)
    );

    lmfc_lane_decode #(
        .OCT_PER_CLK (OCT_PER_CLK),
        .LANE_W      (LANE_W)
    ) i_dec (
        .pos_i       (octet_pos_o),
        .period_i    (mf_len),
        .frame_sel_i (frame_sel_i),
        .strobe_o    (lmfc_strobe_o),
        .lane_o      (lmfc_lane_o),
        .fstart_o    (frame_start_o)
    );

endmodule

// File: rtl/lmfc_align_gen_chk.sv
module lmfc_align_gen_chk
    import lmfc_pkg::*;
#(
    parameter int unsigned OCT_PER_CLK = 4
) (
    input logic                   clk_i,
    input logic                   rst_i,
    input logic [1:0]             frame_sel_i,
    input logic                   mf_sel_i,
    input logic                   one_shot_i,
    input logic                   sref_rise,
    input logic [POS_W-1:0]       octet_pos_o,
    input logic                   lmfc_strobe_o,
    input logic [OCT_PER_CLK-1:0] frame_start_o,
    input logic                   aligned_o,
    input logic                   misalign_o
);

    logic [PER_W-1:0] plen;
    assign plen = mf_octets(frame_sel_i, mf_sel_i);

    // R2: position stays inside the multiframe
    p_pos_range_r2: assert property (@(posedge clk_i) disable iff (rst_i)
        PER_W'(octet_pos_o) < plen);

    // R2: plain advance modulo the multiframe length
    p_advance_r2: assert property (@(posedge clk_i) disable iff (rst_i)
        !sref_rise |=> (int'(octet_pos_o) ==
                        (int'($past(octet_pos_o)) + int'(OCT_PER_CLK)) % int'(plen)));

    // R3: a boundary word off position 0 is followed by a word past octet 0
    p_cross_r3: assert property (@(posedge clk_i) disable iff (rst_i)
        (lmfc_strobe_o && octet_pos_o != '0 && !sref_rise)
            |=> (int'(octet_pos_o) < int'(OCT_PER_CLK)));

    // R4: lane 0 always starts a frame at position 0
    p_frame_lane0_r4: assert property (@(posedge clk_i) disable iff (rst_i)
        (octet_pos_o == '0) |-> frame_start_o[0]);

    // R5: an accepted edge restarts the position one step past octet 0
    p_realign_r5: assert property (@(posedge clk_i) disable iff (rst_i)
        (sref_rise && !(one_shot_i && aligned_o))
            |=> (int'(octet_pos_o) == int'(OCT_PER_CLK)));

    // R6: aligned is sticky and only rises on a detected edge
    p_aligned_hold_r6: assert property (@(posedge clk_i) disable iff (rst_i)
        aligned_o |=> aligned_o);
    p_aligned_cause_r6: assert property (@(posedge clk_i) disable iff (rst_i)
        $rose(aligned_o) |-> $past(sref_rise));

    // R7: misalignment flag is sticky and has an off-boundary cause
    p_mis_hold_r7: assert property (@(posedge clk_i) disable iff (rst_i)
        misalign_o |=> misalign_o);
    p_mis_cause_r7: assert property (@(posedge clk_i) disable iff (rst_i)
        $rose(misalign_o) |-> $past(sref_rise && aligned_o && (octet_pos_o != '0)));

    // R8: one-shot mode never raises the flag after alignment
    p_oneshot_r8: assert property (@(posedge clk_i) disable iff (rst_i)
        (one_shot_i && aligned_o) |=> !$rose(misalign_o));

endmodule

bind lmfc_align_gen lmfc_align_gen_chk #(
    .OCT_PER_CLK (OCT_PER_CLK)
) i_lmfc_align_gen_chk (
    .clk_i         (clk_i),
    .rst_i         (rst_i),
    .frame_sel_i   (frame_sel_i),
    .mf_sel_i      (mf_sel_i),
    .one_shot_i    (one_shot_i),
    .sref_rise     (sref_rise),
    .octet_pos_o   (octet_pos_o),
    .lmfc_strobe_o (lmfc_strobe_o),
    .frame_start_o (frame_start_o),
    .aligned_o     (aligned_o),
    .misalign_o    (misalign_o)
);

// File: tb/test_lmfc_align_gen.sv
`timescale 1ns/1ps

module lmfc_bench_model #(
    parameter int unsigned W = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         sysref,
    input  logic [1:0]   fsel,
    input  logic         ksel,
    input  logic         one_shot,
    output int           e_pos,
    output logic         e_strobe,
    output int           e_lane,
    output logic [W-1:0] e_mask,
    output logic         e_al,
    output logic         e_mis
);
    logic s1, s2;
    int   pos;

    function automatic int f_of(input logic [1:0] fs);
        return (fs == 2'd0) ? 1 : (fs == 2'd1) ? 2 : 4;
    endfunction

    function automatic int p_of(input logic [1:0] fs, input logic ks);
        return f_of(fs) * (ks ? 32 : 16);
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            s1 <= 1'b0; s2 <= 1'b0; pos <= 0; e_al <= 1'b0; e_mis <= 1'b0;
        end else begin
            s1 <= sysref;
            s2 <= s1;
            if (s1 && !s2 && !(one_shot && e_al)) begin
                pos  <= int'(W);
                e_al <= 1'b1;
                if (e_al && pos != 0) e_mis <= 1'b1;
            end else begin
                pos <= (pos + int'(W)) % p_of(fsel, ksel);
            end
        end
    end

    always_comb begin
        int p;
        p        = p_of(fsel, ksel);
        e_pos    = pos;
        e_strobe = (pos == 0) || (pos + int'(W) > p);
        e_lane   = (pos == 0 || !e_strobe) ? 0 : p - pos;
        for (int l = 0; l < int'(W); l++) begin
            e_mask[l] = ((pos + l) % f_of(fsel)) == 0;
        end
    end
endmodule

module test_lmfc_align_gen;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       sysref = 1'b0;
    logic [1:0] fsel = 2'd0;
    logic       ksel = 1'b0;
    logic       one_shot = 1'b0;

    int checks = 0;
    int errors = 0;

    logic [6:0] pos4, pos3;
    logic       stb4, stb3, al4, al3, mis4, mis3;
    logic [1:0] lane4, lane3;
    logic [3:0] mask4;
    logic [2:0] mask3;

    int         xp4, xl4, xp3, xl3;
    logic       xs4, xa4, xm4, xs3, xa3, xm3;
    logic [3:0] xk4;
    logic [2:0] xk3;

    always #2.5 clk = ~clk;

    lmfc_align_gen #(.OCT_PER_CLK(4)) i_lmfc_align_gen (
        .clk_i(clk), .rst_i(rst), .sysref_i(sysref), .frame_sel_i(fsel),
        .mf_sel_i(ksel), .one_shot_i(one_shot), .octet_pos_o(pos4),
        .lmfc_strobe_o(stb4), .lmfc_lane_o(lane4), .frame_start_o(mask4),
        .aligned_o(al4), .misalign_o(mis4));

    lmfc_align_gen #(.OCT_PER_CLK(3)) i_lmfc_align_gen_w3 (
        .clk_i(clk), .rst_i(rst), .sysref_i(sysref), .frame_sel_i(fsel),
        .mf_sel_i(ksel), .one_shot_i(one_shot), .octet_pos_o(pos3),
        .lmfc_strobe_o(stb3), .lmfc_lane_o(lane3), .frame_start_o(mask3),
        .aligned_o(al3), .misalign_o(mis3));

    lmfc_bench_model #(.W(4)) i_model4 (
        .clk(clk), .rst(rst), .sysref(sysref), .fsel(fsel), .ksel(ksel),
        .one_shot(one_shot), .e_pos(xp4), .e_strobe(xs4), .e_lane(xl4),
        .e_mask(xk4), .e_al(xa4), .e_mis(xm4));

    lmfc_bench_model #(.W(3)) i_model3 (
        .clk(clk), .rst(rst), .sysref(sysref), .fsel(fsel), .ksel(ksel),
        .one_shot(one_shot), .e_pos(xp3), .e_strobe(xs3), .e_lane(xl3),
        .e_mask(xk3), .e_al(xa3), .e_mis(xm3));

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic compare_all();
        chk("R2 pos w4", int'(pos4), xp4);
        chk("R3 strobe w4", int'(stb4), int'(xs4));
        chk("R3 lane w4", int'(lane4), xl4);
        chk("R4 mask w4", int'(mask4), int'(xk4));
        chk("R6 aligned w4", int'(al4), int'(xa4));
        chk("R7 misalign w4", int'(mis4), int'(xm4));
        chk("R2 pos w3", int'(pos3), xp3);
        chk("R3 strobe w3", int'(stb3), int'(xs3));
        chk("R3 lane w3", int'(lane3), xl3);
        chk("R4 mask w3", int'(mask3), int'(xk3));
        chk("R6 aligned w3", int'(al3), int'(xa3));
        chk("R7 misalign w3", int'(mis3), int'(xm3));
    endtask

    task automatic tick(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            compare_all();
        end
    endtask

    task automatic do_reset();
        rst = 1'b1;
        sysref = 1'b0;
        tick(2);
        chk("R1 reset pos", int'(pos4), 0);
        chk("R1 reset aligned", int'(al4), 0);
        chk("R1 reset misalign", int'(mis4), 0);
        rst = 1'b0;
    endtask

    task automatic pulse();
        sysref = 1'b1;
        tick(1);
        sysref = 1'b0;
        tick(1);
    endtask

    initial begin
        int seed;
        seed = $urandom(32'h5EED_1234);

        // reset and free run, F=1 K=16 (P=16)
        fsel = 2'd0; ksel = 1'b0; one_shot = 1'b0;
        do_reset();
        tick(3);
        chk("R2 free run pos", int'(pos4), 12);
        chk("R6 not aligned before sysref", int'(al4), 0);

        // first edge aligns, no flag
        pulse();
        chk("R5 realign pos", int'(pos4), 4);
        chk("R6 aligned after first edge", int'(al4), 1);
        chk("R7 first edge no flag", int'(mis4), 0);

        // off-boundary edge sets the flag
        pulse();
        chk("R5 realign pos second", int'(pos4), 4);
        chk("R7 misalign set", int'(mis4), 1);

        // on-boundary edge, flag stays sticky
        tick(2);
        pulse();
        chk("R7 misalign sticky", int'(mis4), 1);

        // held level does not retrigger
        sysref = 1'b1;
        tick(5);
        chk("R5 held level no retrigger", int'(pos4), 0);
        sysref = 1'b0;

        do_reset();
        chk("R1 flag cleared by reset", int'(mis4), 0);

        // boundary inside the word, three octets per clock, P=16
        tick(5);
        chk("R3 w3 strobe at pos 15", int'(stb3), 1);
        chk("R3 w3 lane at pos 15", int'(lane3), 1);
        tick(1);
        chk("R3 w3 no strobe at pos 2", int'(stb3), 0);

        // frame masks, F=2 K=32 and F=4
        fsel = 2'd1; ksel = 1'b1;
        do_reset();
        chk("R4 mask F=2", int'(mask4), 5);
        chk("R3 strobe at 0", int'(stb4), 1);
        tick(1);
        chk("R3 no strobe at 4 of 64", int'(stb4), 0);
        fsel = 2'd2;
        do_reset();
        chk("R4 mask F=4", int'(mask4), 1);

        // one-shot mode ignores later edges
        fsel = 2'd0; ksel = 1'b0; one_shot = 1'b1;
        do_reset();
        tick(3);
        pulse();
        pulse();
        chk("R8 one-shot ignores edge pos", int'(pos4), 12);
        chk("R8 one-shot flag clear", int'(mis4), 0);
        one_shot = 1'b0;

        // periodic sysref every two multiframes
        do_reset();
        tick(3);
        pulse();
        for (int i = 0; i < 20; i++) begin
            tick(6);
            pulse();
        end
        chk("R9 periodic pos", int'(pos4), 4);
        chk("R9 periodic no flag", int'(mis4), 0);

        // constrained random episodes
        for (int ep = 0; ep < 40; ep++) begin
            int per_clk;
            fsel     = 2'($urandom_range(0, 3));
            ksel     = 1'($urandom_range(0, 1));
            one_shot = 1'($urandom_range(0, 1));
            per_clk  = (((fsel == 0) ? 1 : (fsel == 1) ? 2 : 4) * (ksel ? 32 : 16) * 2) / 4;
            do_reset();
            for (int c = 0; c < 2000; c++) begin
                if (ep % 2 == 0) sysref = ($urandom_range(0, 99) < 4);
                else             sysref = ((c % per_clk) == 3) || ($urandom_range(0, 499) == 0);
                tick(1);
            end
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(5.0 * 200000);
        $display("FAIL watchdog all requirements: actual timeout expected completion");
        $display("CHECKS %0d ERRORS %0d", checks + 1, errors + 1);
        $finish;
    end

endmodule